// File: doc/BRIEF.md
# ADC Conversion Command Queue Sequencer

This block runs a list of conversion commands against an analog-to-digital converter. Software fills a 64-entry command table through a write port. A trigger starts a scan at entry 0. For each entry, the block latches the command and drives the channel, sample-window code and bypass flag to the converter front end. It holds a conversion window whose length it derives from those fields. At the end of the window it stores the sample value in a 64-entry result table, at the same index as the command.

Each command word can end the scan with a reserved channel code. In edge-triggered mode, a command can also mark a pause point that splits the list into subqueues, and each new trigger resumes the scan at the next entry. The software-started and gated trigger modes ignore pause points. A trigger that arrives while a scan is running is dropped and recorded in a sticky overrun flag. Status outputs report whether the block is busy, paused or complete, and which entry is current.

Top module: `adc_cmdq_seq`

## Requirements
- R1: A command word is 10 bits: bit 9 pause, bit 8 bypass, bits 7:6 window code, bits 5:0 channel. While a conversion is active, conv_chan_o, conv_win_o and conv_byp_o show the channel, window code and bypass bit of the command being converted.
- R2: Without bypass, conv_active_o stays high for 12 + W cycles, where W is 2, 4, 8 or 16 for window code 0, 1, 2 or 3.
- R3: With bypass on a channel below 60, the two-cycle initial phase is dropped and the window is at least 4 cycles, so the length is 10 + max(W, 4).
- R4: On channels 60 to 62 the bypass bit has no effect: the length is 12 + W.
- R5: Channel code 63 ends the scan without a conversion and sets complete_o, and busy_o falls. After reset, every command entry holds code 63.
- R6: At the end of each conversion, smp_data_i from the last active cycle is written to the result table at the command's index, and can be read on res_rdata_o at res_raddr_i. Result entries reset to zero.
- R7: In edge mode (trig_mode_i = 01), a command with pause set makes paused_o high after its conversion, with cur_idx_o already on the next entry. The next trigger resumes the scan there without setting the overrun flag.
- R8: In software mode (00), gated mode (10) and mode 11, the pause bit is ignored and the scan continues.
- R9: If entry 63 is reached and converted without an end code, the scan stops with complete_o set.
- R10: A trigger while the scan is running and not paused is ignored: the conversion and the index are unchanged, and trig_ovr_o is set and stays set until the next start.
- R11: cur_idx_o gives the index of the current command. After reset, the block is idle with all flags low and the index at 0.
- R12: A trigger while idle starts a scan at index 0 and clears complete_o and trig_ovr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we_i | input | 1 | Command table write enable |
| cmd_waddr_i | input | 6 | Command table write index |
| cmd_wdata_i | input | 10 | Command word to write |
| trig_mode_i | input | 2 | Trigger mode: 00 software, 01 edge, 10 gated |
| trig_i | input | 1 | Trigger pulse |
| smp_data_i | input | RES_W | Converter sample value |
| res_raddr_i | input | 6 | Result table read index |
| res_rdata_o | output | RES_W | Result table read data |
| conv_active_o | output | 1 | Conversion window active |
| conv_chan_o | output | 6 | Channel being converted |
| conv_win_o | output | 2 | Window code being converted |
| conv_byp_o | output | 1 | Bypass flag being converted |
| busy_o | output | 1 | Scan running or paused |
| paused_o | output | 1 | Scan waiting at a pause point |
| complete_o | output | 1 | Scan finished |
| trig_ovr_o | output | 1 | Trigger dropped during a scan |
| cur_idx_o | output | 6 | Current command index |

## Verification
Fixed lists exercise each timing branch separately: plain windows, bypass on an ordinary channel, and bypass on an internal channel. Because the window code and the bypass bit are varied on their own, a wrong length formula is pinned to the branch that produced it. The same list with pause bits runs in software, edge and gated modes, which separates a pause that is honoured from one that is ignored. A list with no end code shows that a scan stops at the table boundary. Random lists, with random modes and end positions, check the lengths, indices and stored results against a bench model of each command.

// File: rtl/adc_cq_pkg.sv
`timescale 1ns/1ps
package adc_cq_pkg;
    localparam int IDX_W  = 6;
    localparam int CHAN_W = 6;
    localparam int CMD_W  = CHAN_W + 4;

    typedef enum logic [1:0] {
        TRG_SW    = 2'b00,
        TRG_EDGE  = 2'b01,
        TRG_GATED = 2'b10
    } cq_trig_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVAL,
        ST_CONV,
        ST_HOLD
    } cq_state_e;

    // field order is decoded by the sequencer: pause is the top bit
    typedef struct packed {
        logic              pause;
        logic              bypass;
        logic [1:0]        win;
        logic [CHAN_W-1:0] chan;
    } cq_cmd_t;
endpackage

// File: rtl/cq_ram.sv
`timescale 1ns/1ps
module cq_ram #(
    parameter int          W       = 10,
    parameter int          DEPTH   = 64,
    parameter int          AW      = $clog2(DEPTH),
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= RST_VAL;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/cq_conv_len.sv
`timescale 1ns/1ps
module cq_conv_len
    import adc_cq_pkg::*;
#(
    parameter int BASE_CLKS     = 10,
    parameter int INIT_CLKS     = 2,
    parameter int WIN_BASE_CLKS = 2,
    parameter int BYP_MIN_CLKS  = 4,
    parameter int SPECIAL_LO    = 60,
    parameter int CNT_W         = 6
) (
    input  cq_cmd_t          cmd_i,
    output logic [CNT_W-1:0] len_o
);
    logic [CNT_W-1:0] win_clks;
    logic [CNT_W-1:0] fin_clks;
    logic             special;
    logic             skip_init;

    always_comb begin
        win_clks  = CNT_W'(WIN_BASE_CLKS) << cmd_i.win;
        special   = (cmd_i.chan >= CHAN_W'(SPECIAL_LO));
        skip_init = cmd_i.bypass && !special;
        if (skip_init) begin
            fin_clks = (win_clks < CNT_W'(BYP_MIN_CLKS)) ? CNT_W'(BYP_MIN_CLKS) : win_clks;
            len_o    = CNT_W'(BASE_CLKS) + fin_clks;
        end else begin
            fin_clks = win_clks;
            len_o    = CNT_W'(BASE_CLKS) + CNT_W'(INIT_CLKS) + fin_clks;
        end
    end
endmodule

// File: rtl/adc_cmdq_seq.sv
`timescale 1ns/1ps
module adc_cmdq_seq
    import adc_cq_pkg::*;
#(
    parameter int RES_W         = 10,
    parameter int BASE_CLKS     = 10,
    parameter int INIT_CLKS     = 2,
    parameter int WIN_BASE_CLKS = 2,
    parameter int BYP_MIN_CLKS  = 4,
    parameter int SPECIAL_LO    = 60,
    parameter int CNT_W         = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we_i,
    input  logic [IDX_W-1:0]  cmd_waddr_i,
    input  logic [CMD_W-1:0]  cmd_wdata_i,
    input  logic [1:0]        trig_mode_i,
    input  logic              trig_i,
    input  logic [RES_W-1:0]  smp_data_i,
    input  logic [IDX_W-1:0]  res_raddr_i,
    output logic [RES_W-1:0]  res_rdata_o,
    output logic              conv_active_o,
    output logic [CHAN_W-1:0] conv_chan_o,
    output logic [1:0]        conv_win_o,
    output logic              conv_byp_o,
    output logic              busy_o,
    output logic              paused_o,
    output logic              complete_o,
    output logic              trig_ovr_o,
    output logic [IDX_W-1:0]  cur_idx_o
);
    localparam int DEPTH    = 1 << IDX_W;
    localparam int LAST_IDX = DEPTH - 1;
    localparam int END_CHAN = (1 << CHAN_W) - 1;

    typedef struct packed {
        cq_state_e        st;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
        cq_cmd_t          cmd;
        logic             cmpl;
        logic             ovr;
    } seq_t;

    seq_t             s_q, s_d;
    logic [CMD_W-1:0] cmd_rdata;
    cq_cmd_t          cmd_rd;
    logic [CNT_W-1:0] conv_len;
    logic             res_we;
    logic             pause_on;

    cq_ram #(
        .W      (CMD_W),
        .DEPTH  (DEPTH),
        .AW     (IDX_W),
        .RST_VAL(CMD_W'(END_CHAN))
    ) u_cmd_ram (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (cmd_we_i),
        .waddr(cmd_waddr_i),
        .wdata(cmd_wdata_i),
        .raddr(s_q.idx),
        .rdata(cmd_rdata)
    );

    cq_ram #(
        .W      (RES_W),
        .DEPTH  (DEPTH),
        .AW     (IDX_W),
        .RST_VAL('0)
    ) u_res_ram (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (res_we),
        .waddr(s_q.idx),
        .wdata(smp_data_i),
        .raddr(res_raddr_i),
        .rdata(res_rdata_o)
    );

    assign cmd_rd = cq_cmd_t'(cmd_rdata);

    cq_conv_len #(
        .BASE_CLKS    (BASE_CLKS),
        .INIT_CLKS    (INIT_CLKS),
        .WIN_BASE_CLKS(WIN_BASE_CLKS),
        .BYP_MIN_CLKS (BYP_MIN_CLKS),
        .SPECIAL_LO   (SPECIAL_LO),
        .CNT_W        (CNT_W)
    ) u_len (
        .cmd_i(cmd_rd),
        .len_o(conv_len)
    );

    // pause points only split the queue in edge-triggered mode
    assign pause_on = s_q.cmd.pause && (cq_trig_e'(trig_mode_i) == TRG_EDGE);

    always_comb begin
        s_d    = s_q;
        res_we = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (trig_i) begin
                    s_d.st   = ST_EVAL;
                    s_d.idx  = '0;
                    s_d.cmpl = 1'b0;
                    s_d.ovr  = 1'b0;
                end
            end
            ST_EVAL: begin
                if (trig_i) begin
                    s_d.ovr = 1'b1;
                end
                if (cmd_rd.chan == CHAN_W'(END_CHAN)) begin
                    s_d.st   = ST_IDLE;
                    s_d.cmpl = 1'b1;
                end else begin
                    s_d.st  = ST_CONV;
                    s_d.cmd = cmd_rd;
                    s_d.cnt = conv_len;
                end
            end
            ST_CONV: begin
                if (trig_i) begin
                    s_d.ovr = 1'b1;
                end
                s_d.cnt = s_q.cnt - CNT_W'(1);
                if (s_q.cnt == CNT_W'(1)) begin
                    res_we = 1'b1;
                    if (s_q.idx == IDX_W'(LAST_IDX)) begin
                        s_d.st   = ST_IDLE;
                        s_d.cmpl = 1'b1;
                    end else begin
                        s_d.idx = s_q.idx + IDX_W'(1);
                        s_d.st  = pause_on ? ST_HOLD : ST_EVAL;
                    end
                end
            end
            ST_HOLD: begin
                if (trig_i) begin
                    s_d.st = ST_EVAL;
                end
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign conv_active_o = (s_q.st == ST_CONV);
    assign conv_chan_o   = s_q.cmd.chan;
    assign conv_win_o    = s_q.cmd.win;
    assign conv_byp_o    = s_q.cmd.bypass;
    assign busy_o        = (s_q.st != ST_IDLE);
    assign paused_o      = (s_q.st == ST_HOLD);
    assign complete_o    = s_q.cmpl;
    assign trig_ovr_o    = s_q.ovr;
    assign cur_idx_o     = s_q.idx;
endmodule

// File: rtl/cq_chk.sv
`timescale 1ns/1ps
module cq_chk
    import adc_cq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              trig_i,
    input logic [1:0]        trig_mode_i,
    input logic              conv_active_o,
    input logic [CHAN_W-1:0] conv_chan_o,
    input logic [IDX_W-1:0]  cur_idx_o,
    input logic              busy_o,
    input logic              paused_o,
    input logic              complete_o,
    input logic              trig_ovr_o
);
    // R2: a conversion window only exists inside a running scan
    a_r2_active_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
        conv_active_o |-> busy_o);

    // R1: command fields hold steady through a conversion
    a_r1_chan_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_active_o && $past(conv_active_o)) |-> $stable(conv_chan_o));

    // R5: the end code never reaches the converter
    a_r5_no_end_conv: assert property (@(posedge clk) disable iff (!rst_n)
        conv_active_o |-> (conv_chan_o != CHAN_W'((1 << CHAN_W) - 1)));

    // R5: complete only when idle
    a_r5_complete_idle: assert property (@(posedge clk) disable iff (!rst_n)
        complete_o |-> !busy_o);

    // R7: paused and converting are exclusive
    a_r7_pause_no_conv: assert property (@(posedge clk) disable iff (!rst_n)
        paused_o |-> !conv_active_o);

    // R8: a pause is entered only in edge mode
    a_r8_pause_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused_o) |-> ($past(trig_mode_i) == 2'b01));

    // R10: the overrun flag clears only on a fresh start from idle
    a_r10_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trig_ovr_o) |-> ($past(trig_i) && !$past(busy_o)));

    // R11: index is steady while a conversion runs
    a_r11_idx_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_active_o && $past(conv_active_o)) |-> $stable(cur_idx_o));
endmodule

bind adc_cmdq_seq cq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_i       (trig_i),
    .trig_mode_i  (trig_mode_i),
    .conv_active_o(conv_active_o),
    .conv_chan_o  (conv_chan_o),
    .cur_idx_o    (cur_idx_o),
    .busy_o       (busy_o),
    .paused_o     (paused_o),
    .complete_o   (complete_o),
    .trig_ovr_o   (trig_ovr_o)
);

// File: tb/tb_adc_cmdq_seq.sv
`timescale 1ns/1ps
module tb_adc_cmdq_seq;
    localparam int RES_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_we = 1'b0;
    logic [5:0]       cmd_waddr = '0;
    logic [9:0]       cmd_wdata = '0;
    logic [1:0]       trig_mode = 2'b00;
    logic             trig = 1'b0;
    logic [RES_W-1:0] smp_data;
    logic [5:0]       res_raddr = '0;
    logic [RES_W-1:0] res_rdata;
    logic             conv_active;
    logic [5:0]       conv_chan;
    logic [1:0]       conv_win;
    logic             conv_byp;
    logic             busy, paused, complete, trig_ovr;
    logic [5:0]       cur_idx;

    int               n_chk = 0;
    int               n_fail = 0;
    logic [9:0]       cmd_sh [64];
    logic [RES_W-1:0] res_sh [64];
    logic [RES_W-1:0] salt = '0;

    always #4 clk = ~clk;

    assign smp_data = RES_W'(conv_chan * 37) ^ salt;

    adc_cmdq_seq dut (
        .clk(clk), .rst_n(rst_n), .cmd_we_i(cmd_we), .cmd_waddr_i(cmd_waddr),
        .cmd_wdata_i(cmd_wdata), .trig_mode_i(trig_mode), .trig_i(trig),
        .smp_data_i(smp_data), .res_raddr_i(res_raddr), .res_rdata_o(res_rdata),
        .conv_active_o(conv_active), .conv_chan_o(conv_chan), .conv_win_o(conv_win),
        .conv_byp_o(conv_byp), .busy_o(busy), .paused_o(paused),
        .complete_o(complete), .trig_ovr_o(trig_ovr), .cur_idx_o(cur_idx)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    function automatic int exp_len(input logic [9:0] w);
        int win;
        win = 2 << w[7:6];
        if (w[8] && w[5:0] < 6'd60) return 10 + ((win < 4) ? 4 : win);
        return 12 + win;
    endfunction

    function automatic logic [RES_W-1:0] exp_smp(input logic [5:0] ch);
        return RES_W'(ch * 37) ^ salt;
    endfunction

    task automatic write_cmd(input int a, input logic [9:0] w);
        @(negedge clk);
        cmd_we = 1'b1; cmd_waddr = 6'(a); cmd_wdata = w;
        @(negedge clk);
        cmd_we = 1'b0;
        cmd_sh[a] = w;
    endtask

    task automatic pulse_trig();
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic wait_active(input string req);
        int t;
        t = 0;
        while (!conv_active && t < 2000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 2000) chk(1'b0, req, 0, 1);
    endtask

    task automatic wait_idle(input string req);
        int t;
        t = 0;
        while (busy && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 3000) chk(1'b0, req, 1, 0);
    endtask

    task automatic run_queue(input logic [1:0] mode);
        int idx;
        bit fin;
        idx = 0; fin = 0;
        trig_mode = mode;
        @(negedge clk);
        pulse_trig();
        while (!fin) begin
            logic [9:0] w;
            int n;
            w = cmd_sh[idx];
            if (w[5:0] == 6'd63) begin
                wait_idle("R5");
                chk(complete == 1'b1 && !busy, "R5 end code completes", int'(complete), 1);
                fin = 1;
            end else begin
                wait_active("R2");
                chk(cur_idx == 6'(idx), "R11 index", int'(cur_idx), idx);
                chk({conv_byp, conv_win, conv_chan} == w[8:0], "R1 fields",
                    int'({conv_byp, conv_win, conv_chan}), int'(w[8:0]));
                n = 0;
                while (conv_active && n < 100) begin
                    n++;
                    @(negedge clk);
                end
                if (!w[8]) chk(n == exp_len(w), "R2 length", n, exp_len(w));
                else if (w[5:0] >= 6'd60) chk(n == exp_len(w), "R4 length", n, exp_len(w));
                else chk(n == exp_len(w), "R3 length", n, exp_len(w));
                res_sh[idx] = exp_smp(w[5:0]);
                if (idx == 63) begin
                    chk(!busy && complete, "R9 stop at last entry", int'(busy), 0);
                    fin = 1;
                end else if (w[9] && mode == 2'b01) begin
                    chk(paused && cur_idx == 6'(idx + 1), "R7 paused", int'(paused), 1);
                    pulse_trig();
                    chk(!trig_ovr && !paused, "R7 resume without overrun", int'(trig_ovr), 0);
                end else if (w[9]) begin
                    chk(!paused, "R8 pause ignored", int'(paused), 0);
                end
                idx++;
            end
        end
        for (int a = 0; a < 64; a++) begin
            res_raddr = 6'(a);
            #1;
            chk(res_rdata == res_sh[a], "R6 result", int'(res_rdata), int'(res_sh[a]));
        end
    endtask

    task automatic load_fixed();
        write_cmd(0, {1'b0, 1'b0, 2'd0, 6'd5});
        write_cmd(1, {1'b1, 1'b1, 2'd3, 6'd12});
        write_cmd(2, {1'b0, 1'b1, 2'd0, 6'd61});
        write_cmd(3, {1'b1, 1'b1, 2'd1, 6'd7});
        write_cmd(4, {1'b0, 1'b0, 2'd2, 6'd60});
        write_cmd(5, {1'b0, 1'b0, 2'd0, 6'd63});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 1, 0);
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd24681);
        for (int a = 0; a < 64; a++) begin
            cmd_sh[a] = 10'd63;
            res_sh[a] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(!busy && !paused && !complete && !trig_ovr && !conv_active,
            "R11 reset flags", int'({busy, paused, complete, trig_ovr}), 0);
        chk(cur_idx == 6'd0, "R11 reset index", int'(cur_idx), 0);

        // R5: reset table holds end codes, so a scan completes at once
        salt = 10'h2a5;
        run_queue(2'b00);

        // fixed list, software mode: R2 R3 R4 R8
        load_fixed();
        salt = 10'h13c;
        run_queue(2'b00);
        // same list in edge mode: R7
        salt = 10'h0f1;
        run_queue(2'b01);
        // gated mode: R8
        salt = 10'h377;
        run_queue(2'b10);

        // R10 overrun, R12 restart clears it
        trig_mode = 2'b01;
        @(negedge clk);
        pulse_trig();
        wait_active("R10");
        pulse_trig();
        chk(trig_ovr == 1'b1, "R10 overrun set", int'(trig_ovr), 1);
        chk(conv_active && cur_idx == 6'd0, "R10 trigger ignored", int'(cur_idx), 0);
        while (busy) begin
            if (paused) pulse_trig();
            else @(negedge clk);
        end
        chk(trig_ovr == 1'b1, "R10 overrun sticky", int'(trig_ovr), 1);
        chk(complete == 1'b1, "R12 complete before restart", int'(complete), 1);
        pulse_trig();
        chk(!trig_ovr && !complete && busy && cur_idx == 6'd0, "R12 restart clears flags",
            int'({trig_ovr, complete, busy}), 1);
        while (busy) begin
            if (paused) pulse_trig();
            else @(negedge clk);
        end
        for (int a = 0; a < 6; a++) res_sh[a] = RES_W'(cmd_sh[a][5:0] * 37) ^ salt;
        res_sh[5] = '0;

        // R9: full table without an end code, pause bits set, gated mode
        for (int a = 0; a < 64; a++) begin
            write_cmd(a, {1'b1, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                          6'($urandom_range(0, 62))});
        end
        salt = 10'h0aa;
        run_queue(2'b10);

        // random lists
        for (int r = 0; r < 6; r++) begin
            int endpos;
            endpos = $urandom_range(1, 80);
            for (int a = 0; a < 64; a++) begin
                logic [9:0] w;
                w = 10'($urandom);
                w[5:0] = 6'($urandom_range(0, 62));
                if (a == endpos) w[5:0] = 6'd63;
                write_cmd(a, w);
            end
            salt = 10'($urandom);
            run_queue(2'($urandom_range(0, 2)));
        end

        finish_run();
    end
endmodule